// File: doc/BRIEF.md
# Handshake Word Synchronizer

This block moves one multi-bit word at a time from a sender on a foreign clock into the local clock domain. The sender puts a word on its data lines and raises a request strobe. Only that strobe is brought into the local domain. It passes through a short chain of local flip-flops. The data lines pass through no per-bit synchronizer at all. The local side copies the whole word into a register in a single step, once the resynchronized strobe shows the word has had time to settle.

After the copy, the block raises an acknowledge line toward the sender, and it gives local logic a one-cycle marker together with the captured word. The exchange is a four-phase handshake. The sender keeps the word steady until it sees the acknowledge, then drops its strobe. The acknowledge falls once the local side sees the strobe low. Only after that can a new word be taken.

Top module: `vld_word_sync`

## Requirements
- R1: The request strobe reaches the control logic only through two cascaded local flip-flops. If the strobe is first sampled high at local edge E0, the capture happens at edge E0+2, so `dst_valid_o` and `src_ack_o` are first seen high after that third edge, and they are low after E0 and after E0+1.
- R2: The word on `src_data_i` at the capture edge is loaded whole into `dst_data_o`. Held stable by the sender through the handshake, it equals the driven word.
- R3: `src_ack_o` rises in the same cycle as the `dst_valid_o` marker.
- R4: `src_ack_o` stays high while the resynchronized strobe is high. If the strobe is first sampled low at edge F0, the acknowledge is still high after F0 and after F0+1, and low after F0+2.
- R5: `dst_valid_o` is high for exactly one local cycle per transfer, no matter how long the strobe stays high.
- R6: While the acknowledge is high, a change on `src_data_i` has no effect on `dst_data_o`.
- R7: A synchronous active-high `rst` clears both synchronizer stages, the word register (to zero) and the acknowledge. A strobe held high through reset gives its first marker only after the third edge following release.
- R8: With the sender on an unrelated clock at a non-integer frequency ratio, every word is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid_i | input | 1 | Request strobe from the foreign domain |
| src_data_i | input | DATA_W | Word from the foreign domain |
| src_ack_o | output | 1 | Acknowledge returned to the sender |
| dst_data_o | output | DATA_W | Captured word, held between transfers |
| dst_valid_o | output | 1 | One-cycle marker of a new word |

## Verification
The bench counts edges after the strobe rises. A chain with one stage too few or too many moves the marker a cycle early or late. Strobes are held for long stretches, where a level-driven marker would repeat and duplicate words. The data lines are changed while the acknowledge is high, where a register that loads every cycle would corrupt the held word. The bench also checks the acknowledge fall timing, a reset taken with the strobe already high, and a run against an unrelated sender clock. There, a lost or doubled handshake shows up as a wrong word count or a misordered word.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HELD = 1'b1
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      ack;
        logic      pulse;
    } hs_ctl_t;

    localparam hs_ctl_t HS_RESET = '{st: HS_IDLE, ack: 1'b0, pulse: 1'b0};
endpackage

// File: rtl/vsync_ff.sv
module vsync_ff #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_i};
        end else begin : g_single
            always_comb chain_d = async_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/vsync_hs_fsm.sv
module vsync_hs_fsm
    import vsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld_s_i,
    output logic take_o,
    output logic ack_o,
    output logic pulse_o
);
    hs_ctl_t ctl_d, ctl_q;
    logic    take;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        take        = 1'b0;
        case (ctl_q.st)
            HS_IDLE: begin
                if (vld_s_i) begin
                    take        = 1'b1;
                    ctl_d.st    = HS_HELD;
                    ctl_d.ack   = 1'b1;
                    ctl_d.pulse = 1'b1;
                end
            end
            HS_HELD: begin
                if (!vld_s_i) begin
                    ctl_d.st  = HS_IDLE;
                    ctl_d.ack = 1'b0;
                end
            end
            default: ctl_d = HS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= HS_RESET;
        else     ctl_q <= ctl_d;
    end

    assign take_o  = take;
    assign ack_o   = ctl_q.ack;
    assign pulse_o = ctl_q.pulse;

    // R4: the acknowledge is held while the resynchronized strobe stays high
    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_o && vld_s_i) |=> ack_o);

    // R5: marker never lasts two cycles
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/vsync_word_reg.sv
module vsync_word_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (take_i) word_d = d_i;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign q_o = word_q;

    // R6: outside a capture edge the held word does not move
    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(q_o));
endmodule

// File: rtl/vld_word_sync.sv
module vld_word_sync #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ack_o,
    output logic [DATA_W-1:0] dst_data_o,
    output logic              dst_valid_o
);
    logic vld_s;
    logic take;

    vsync_ff #(.STAGES(SYNC_STAGES)) u_vld_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_valid_i),
        .sync_o  (vld_s)
    );

    vsync_hs_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .vld_s_i (vld_s),
        .take_o  (take),
        .ack_o   (src_ack_o),
        .pulse_o (dst_valid_o)
    );

    vsync_word_reg #(.DATA_W(DATA_W)) u_word (
        .clk    (clk),
        .rst    (rst),
        .take_i (take),
        .d_i    (src_data_i),
        .q_o    (dst_data_o)
    );

    // R3: acknowledge rises together with the marker
    assert_ack_with_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(src_ack_o) |-> dst_valid_o);

    // R1: a marker means the strobe was high three edges earlier
    assert_two_stage_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(dst_valid_o) |-> $past(src_valid_i, 3));

    // R4: acknowledge falls only after the strobe was low three edges earlier
    assert_ack_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(src_ack_o) |-> !$past(src_valid_i, 3));
endmodule

// File: tb/vld_word_sync_tb.sv
`timescale 1ns/100ps
module vld_word_sync_tb;
    localparam int W = 16;
    localparam int N = 8;

    localparam logic [W-1:0] TBL_WORD [N] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h8000,
                                              16'h1234, 16'h0000, 16'h7E7E, 16'hBEEF};
    localparam int TBL_HOLD [N] = '{0, 3, 9, 1, 20, 2, 5, 40};

    logic clk = 1'b0, sclk = 1'b0;
    logic rst = 1'b1;
    logic src_valid = 1'b0;
    logic [W-1:0] src_data = '0;
    logic src_ack, dst_valid;
    logic [W-1:0] dst_data;

    int n_chk = 0, n_bad = 0;
    bit async_on = 1'b0;
    int rx_idx = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always #16.5 sclk = ~sclk;

    vld_word_sync #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .src_valid_i(src_valid), .src_data_i(src_data),
        .src_ack_o(src_ack), .dst_data_o(dst_data), .dst_valid_o(dst_valid)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // directed transfer with strobe changed on local negedges
    task automatic xfer(input logic [W-1:0] w, input int hold);
        @(negedge clk);
        src_data  = w;
        src_valid = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R1 early marker", {15'd0, dst_valid}, 16'd0);
        end
        @(negedge clk);
        chk("R1 marker on third edge", {15'd0, dst_valid}, 16'd1);
        chk("R3 ack with marker", {15'd0, src_ack}, 16'd1);
        chk("R2 captured word", dst_data, w);
        src_data = ~w;                       // R6 change while acknowledged
        for (int k = 0; k < hold + 1; k++) begin
            @(negedge clk);
            chk("R5 single marker", {15'd0, dst_valid}, 16'd0);
            chk("R6 word held", dst_data, w);
        end
        src_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R4 ack still high", {15'd0, src_ack}, 16'd1);
        end
        @(negedge clk);
        chk("R4 ack low", {15'd0, src_ack}, 16'd0);
        chk("R6 word held after ack", dst_data, w);
    endtask

    // receiver monitor for the unrelated-clock phase (R8)
    always @(negedge clk) begin
        if (async_on && dst_valid) begin
            if (rx_idx < N) chk("R8 word order", dst_data, TBL_WORD[N-1-rx_idx]);
            rx_idx++;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset ack", {15'd0, src_ack}, 16'd0);
        chk("R7 reset marker", {15'd0, dst_valid}, 16'd0);
        chk("R7 reset word", dst_data, 16'd0);
        rst = 1'b0;

        for (int i = 0; i < N; i++) xfer(TBL_WORD[i], TBL_HOLD[i]);

        // R7: reset with strobe high clears word and restarts the chain
        @(negedge clk);
        src_valid = 1'b1;
        src_data  = 16'h5A5A;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 word cleared", dst_data, 16'd0);
        chk("R7 ack cleared", {15'd0, src_ack}, 16'd0);
        rst = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R7 no early marker", {15'd0, dst_valid}, 16'd0);
        end
        @(negedge clk);
        chk("R7 marker after release", {15'd0, dst_valid}, 16'd1);
        chk("R7 word after release", dst_data, 16'h5A5A);
        src_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 idle after reset xfer", {15'd0, src_ack}, 16'd0);

        // R8: sender on an unrelated 33 ns clock
        async_on = 1'b1;
        for (int i = 0; i < N; i++) begin
            @(posedge sclk);
            src_data  = TBL_WORD[N-1-i];
            src_valid = 1'b1;
            do @(posedge sclk); while (!src_ack);
            src_valid = 1'b0;
            src_data  = 16'hDEAD;
            do @(posedge sclk); while (src_ack);
        end
        repeat (10) @(negedge clk);
        chk("R8 transfer count", rx_idx[W-1:0], N[W-1:0]);

        done = 1'b1;
        summary();
    end
endmodule